// File: doc/BRIEF.md
# Configuration Register Space Responder

This block answers configuration-space accesses for a single emulated target on a shared bus. A requester presents an offset, a size flag and, for writes, a data word. Reads come back one cycle later with a response strobe. The space holds fixed identity words, a class code, a header-type byte and a writable command register. It also holds six base-address slots, of which only the first two store anything, and a short chain of capability headers that software follows from a fixed pointer.

Slot 0 claims a 1-byte I/O window and slot 1 claims a 256-byte 32-bit memory window. Each slot adds its own space-type bits to whatever is written. A read masks the stored base down to its window size, so enumeration software can size a window by writing all ones and reading back. The last link of the capability chain depends on a strap pin. When the strap is high, the chain continues to an enhanced-allocation header. When it is low, the chain stops after the MSI-X header.

The request side uses valid/ready. Ready is held high at all times, so a request is taken in every cycle in which valid is high. The response side has no back-pressure: the requester must capture the response in the cycle in which `rsp_valid` is high. A write takes effect at the edge that accepts it and produces no response.

Top module: `cfg_space_responder`

## Requirements
- R1: `req_ready` is always 1. In the cycle after a read is accepted, `rsp_valid` is 1 and `rsp_data` carries the result. A write gives no response, and `rsp_valid` is 0 in every other cycle.
- R2: Offset 0x00 reads the vendor identifier and offset 0x02 reads the device identifier, each in bits 15:0. Offset 0x0E (header type) always reads 0.
- R3: Offset 0x04 is a 16-bit command register. It resets to 0, and a write stores `req_wdata[15:0]`. A read returns the stored value with bits 31:16 at zero.
- R4: Offset 0x10 (slot 0, I/O) reads the last written word with bit 0 forced to 1. Because its window is 1 byte, no other bits are masked. After reset it reads 0x00000001.
- R5: Offset 0x14 (slot 1, 32-bit memory) reads the last written word with bits 7:0 cleared. Writing 0xFFFFFFFF therefore reads back 0xFFFFFF00. After reset it reads 0.
- R6: Offsets 0x18, 0x1C, 0x20 and 0x24 (slots 2 to 5) ignore writes and always read 0.
- R7: `req_size` is 0 for a byte access and 1 for a dword access. At offset 0x0A, a byte read returns only the sub-class in bits 7:0. A dword read returns the class code in bits 15:8 and the sub-class in bits 7:0. Offset 0x0B returns the class code.
- R8: The capability pointer at 0x34 reads 0x40. The power-management header at 0x40 reads 0x00005001 (next 0x50, ID 0x01), and offset 0x41 reads the next pointer 0x50.
- R9: The express header at 0x50 reads 0x00007010 (next 0x70, ID 0x10), and 0x51 reads 0x70. Its device-capabilities word at 0x54 reads 1: bits 2:0 = 001 encode a maximum payload of 256 bytes.
- R10: With `ea_strap` high, the MSI-X header at 0x70 reads 0x00008011 and 0x71 reads 0x80. With `ea_strap` low, 0x70 reads 0x00000011 and 0x71 reads 0.
- R11: The enhanced-allocation header at 0x80 reads 0x00040014 (entry count 4 in bits 23:16, ID 0x14), and its next pointer at 0x81 reads 0.
- R12: Any offset not listed above reads 0. A write to any offset other than 0x04, 0x10 or 0x14 changes no readable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_strap | input | 1 | Extends the capability chain to the enhanced-allocation header |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W (12) | Byte offset in configuration space |
| req_size | input | 1 | 0 = byte access, 1 = dword access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |

## Verification
The bench writes all ones to every slot. A design that masked slot 1 with the wrong window width, or dropped slot 0's type bit, would return the wrong sizing pattern, and one that let slots 2 to 5 store a value would read that value back instead of zero. Both strap settings are exercised on the MSI-X header and its next pointer, which catches a chain that ignores the strap or terminates at the wrong place. Byte and dword reads of the class-device offset catch a size decode that is swapped or ignored. Random reads and writes compare against a shadow model, so a write that leaks into a read-only word shows up as a mismatch.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  // Header offsets (software decodes these positions)
  localparam int OFS_VENDOR   = 'h00;
  localparam int OFS_DEVICE   = 'h02;
  localparam int OFS_COMMAND  = 'h04;
  localparam int OFS_SUBCLASS = 'h0A;
  localparam int OFS_CLASS    = 'h0B;
  localparam int OFS_HDRTYPE  = 'h0E;
  localparam int OFS_BAR_BASE = 'h10;
  localparam int OFS_CAPPTR   = 'h34;
  localparam int NUM_BARS     = 6;
  localparam int NUM_WR_BARS  = 2;

  // Capability chain layout
  localparam int CAP_PM_OFS   = 'h40;
  localparam int CAP_EXP_OFS  = 'h50;
  localparam int CAP_MSIX_OFS = 'h70;
  localparam int CAP_EA_OFS   = 'h80;
  localparam int CAP_NEXT     = 1;
  localparam int EXP_DEVCAP   = 4;

  localparam logic [7:0] ID_PM   = 8'h01;
  localparam logic [7:0] ID_EXP  = 8'h10;
  localparam logic [7:0] ID_MSIX = 8'h11;
  localparam logic [7:0] ID_EA   = 8'h14;
  localparam logic [7:0] EA_ENTRIES = 8'd4;
  localparam logic [2:0] PAYLOAD_256 = 3'b001;

  typedef enum logic {SZ_BYTE = 1'b0, SZ_DWORD = 1'b1} acc_size_e;
endpackage

// File: rtl/cfg_writable_regs.sv
module cfg_writable_regs
  import cfg_space_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_offset,
  input  logic [31:0]      wr_data,
  output logic [15:0]      cmd,
  output logic [31:0]      bar_raw [NUM_WR_BARS]
);
  localparam logic [OFS_W-1:0] CMD_ADDR = OFS_W'(OFS_COMMAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd <= '0;
    else if (wr_en && wr_offset == CMD_ADDR)
      cmd <= wr_data[15:0];
  end

  for (genvar g = 0; g < NUM_WR_BARS; g++) begin : g_bar
    localparam logic [OFS_W-1:0] BAR_ADDR = OFS_W'(OFS_BAR_BASE + 4 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bar_raw[g] <= '0;
      else if (wr_en && wr_offset == BAR_ADDR)
        bar_raw[g] <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_bar_view.sv
module cfg_bar_view
  import cfg_space_pkg::*;
#(
  parameter int IO_WIN  = 1,
  parameter int MEM_WIN = 256
) (
  input  logic [31:0] bar_raw [NUM_WR_BARS],
  output logic [31:0] bar_rd  [NUM_BARS]
);
  localparam logic [31:0] IO_MASK  = ~(32'(IO_WIN) - 32'd1);
  localparam logic [31:0] MEM_MASK = ~(32'(MEM_WIN) - 32'd1);
  localparam logic [31:0] IO_TYPE  = 32'h1;
  localparam logic [31:0] MEM_TYPE = 32'h0;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_view
    if (g == 0) begin : g_io
      assign bar_rd[g] = (bar_raw[0] & IO_MASK) | IO_TYPE;
    end else if (g == 1) begin : g_mem
      assign bar_rd[g] = (bar_raw[1] & MEM_MASK) | MEM_TYPE;
    end else begin : g_none
      assign bar_rd[g] = '0;
    end
  end
endmodule

// File: rtl/cfg_cap_chain.sv
module cfg_cap_chain
  import cfg_space_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic [OFS_W-1:0] offset,
  input  logic             ea_strap,
  output logic [31:0]      cap_data
);
  localparam logic [7:0] P_PM   = 8'(CAP_PM_OFS);
  localparam logic [7:0] P_EXP  = 8'(CAP_EXP_OFS);
  localparam logic [7:0] P_MSIX = 8'(CAP_MSIX_OFS);
  localparam logic [7:0] P_EA   = 8'(CAP_EA_OFS);

  logic [7:0] msix_next;
  assign msix_next = ea_strap ? P_EA : 8'h00;

  always_comb begin
    cap_data = '0;
    case (offset)
      OFS_W'(OFS_CAPPTR):              cap_data = {24'h0, P_PM};
      OFS_W'(CAP_PM_OFS):              cap_data = {16'h0, P_EXP, ID_PM};
      OFS_W'(CAP_PM_OFS + CAP_NEXT):   cap_data = {24'h0, P_EXP};
      OFS_W'(CAP_EXP_OFS):             cap_data = {16'h0, P_MSIX, ID_EXP};
      OFS_W'(CAP_EXP_OFS + CAP_NEXT):  cap_data = {24'h0, P_MSIX};
      OFS_W'(CAP_EXP_OFS + EXP_DEVCAP): cap_data = {29'h0, PAYLOAD_256};
      OFS_W'(CAP_MSIX_OFS):            cap_data = {16'h0, msix_next, ID_MSIX};
      OFS_W'(CAP_MSIX_OFS + CAP_NEXT): cap_data = {24'h0, msix_next};
      OFS_W'(CAP_EA_OFS):              cap_data = {8'h0, EA_ENTRIES, 8'h00, ID_EA};
      OFS_W'(CAP_EA_OFS + CAP_NEXT):   cap_data = '0;
      default:                         cap_data = '0;
    endcase
  end
endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
  import cfg_space_pkg::*;
#(
  parameter int          OFS_W     = 12,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h5A17,
  parameter logic [7:0]  CLASS_CODE = 8'h11,
  parameter logic [7:0]  SUB_CLASS  = 8'h80,
  parameter int          IO_WIN    = 1,
  parameter int          MEM_WIN   = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ea_strap,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic             req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data
);
  logic        wr_en, rd_en;
  logic [15:0] cmd_q;
  logic [31:0] bar_raw [NUM_WR_BARS];
  logic [31:0] bar_rd  [NUM_BARS];
  logic [31:0] cap_data;
  logic [31:0] rd_data;

  assign req_ready = 1'b1;
  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  cfg_writable_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(req_offset),
    .wr_data(req_wdata), .cmd(cmd_q), .bar_raw(bar_raw)
  );

  cfg_bar_view #(.IO_WIN(IO_WIN), .MEM_WIN(MEM_WIN)) u_bars (
    .bar_raw(bar_raw), .bar_rd(bar_rd)
  );

  cfg_cap_chain #(.OFS_W(OFS_W)) u_caps (
    .offset(req_offset), .ea_strap(ea_strap), .cap_data(cap_data)
  );

  always_comb begin
    rd_data = cap_data;
    case (req_offset)
      OFS_W'(OFS_VENDOR):  rd_data = {16'h0, VENDOR_ID};
      OFS_W'(OFS_DEVICE):  rd_data = {16'h0, DEVICE_ID};
      OFS_W'(OFS_COMMAND): rd_data = {16'h0, cmd_q};
      OFS_W'(OFS_SUBCLASS):
        rd_data = (acc_size_e'(req_size) == SZ_BYTE) ? {24'h0, SUB_CLASS}
                                                     : {16'h0, CLASS_CODE, SUB_CLASS};
      OFS_W'(OFS_CLASS):   rd_data = {24'h0, CLASS_CODE};
      OFS_W'(OFS_HDRTYPE): rd_data = '0;
      default: ;
    endcase
    for (int i = 0; i < NUM_BARS; i++)
      if (req_offset == OFS_W'(OFS_BAR_BASE + 4 * i)) rd_data = bar_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_data;
    end
  end
endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [OFS_W-1:0] req_offset,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_data,
  input logic [15:0]      cmd_q
);
  p_rsp_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  p_hdr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_offset) == OFS_W'('h0E)) |-> rsp_data == 32'h0);

  p_cmd_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_offset == OFS_W'('h04)) |=> cmd_q == $past(req_wdata[15:0]));

  p_io_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_offset) == OFS_W'('h10)) |-> rsp_data[0]);

  p_mem_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_offset) == OFS_W'('h14)) |-> rsp_data[7:0] == 8'h00);

  p_upper_slots_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(req_offset) == OFS_W'('h18) || $past(req_offset) == OFS_W'('h1C) ||
                   $past(req_offset) == OFS_W'('h20) || $past(req_offset) == OFS_W'('h24)))
    |-> rsp_data == 32'h0);
endmodule

bind cfg_space_responder cfg_space_checker #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .cmd_q(cmd_q)
);

// File: tb/tb_cfg_space_responder.sv
module tb_cfg_space_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ea_strap = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_offset = '0;
  logic        req_size = 1'b1;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_cmd  = '0;
  logic [31:0] m_slot0 = '0;
  logic [31:0] m_slot1 = '0;

  always #4 clk = ~clk;

  cfg_space_responder dut (
    .clk(clk), .rst_n(rst_n), .ea_strap(ea_strap), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  function automatic logic [31:0] exp_read(input logic [11:0] o, input logic sz, input logic st);
    case (o)
      12'h000: return 32'h0000C0DE;
      12'h002: return 32'h00005A17;
      12'h004: return {16'h0, m_cmd};
      12'h00A: return sz ? 32'h00001180 : 32'h00000080;
      12'h00B: return 32'h00000011;
      12'h010: return m_slot0 | 32'h1;
      12'h014: return m_slot1 & 32'hFFFFFF00;
      12'h034: return 32'h00000040;
      12'h040: return 32'h00005001;
      12'h041: return 32'h00000050;
      12'h050: return 32'h00007010;
      12'h051: return 32'h00000070;
      12'h054: return 32'h00000001;
      12'h070: return st ? 32'h00008011 : 32'h00000011;
      12'h071: return st ? 32'h00000080 : 32'h00000000;
      12'h080: return 32'h00040014;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] o);
    case (o)
      12'h000, 12'h002, 12'h00E: return "R2";
      12'h004: return "R3";
      12'h010: return "R4";
      12'h014: return "R5";
      12'h018, 12'h01C, 12'h020, 12'h024: return "R6";
      12'h00A, 12'h00B: return "R7";
      12'h034, 12'h040, 12'h041: return "R8";
      12'h050, 12'h051, 12'h054: return "R9";
      12'h070, 12'h071: return "R10";
      12'h080, 12'h081: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [11:0] pick_offset();
    logic [11:0] list [24] = '{12'h000, 12'h002, 12'h004, 12'h00A, 12'h00B, 12'h00E,
                               12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h024,
                               12'h034, 12'h040, 12'h041, 12'h050, 12'h051, 12'h054,
                               12'h070, 12'h071, 12'h080, 12'h081, 12'h0C8, 12'h3FC};
    return list[$urandom_range(0, 23)];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] o, input logic sz);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = o; req_size = sz;
    exp = exp_read(o, sz, ea_strap);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {31'h0, rsp_valid}, 32'h1);
    check(tag_of(o), rsp_data, exp);
  endtask

  task automatic wr(input logic [11:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = o; req_wdata = d; req_size = 1'b1;
    case (o)
      12'h004: m_cmd = d[15:0];
      12'h010: m_slot0 = d;
      12'h014: m_slot1 = d;
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R1", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'h0, rsp_valid}, 32'h0);
    check("R1", {31'h0, req_ready}, 32'h1);
    // reset state: R3, R4, R5
    rd(12'h004, 1'b1);
    rd(12'h010, 1'b1);
    rd(12'h014, 1'b1);

    // full walk with strap low then high: R2, R7..R11
    for (int s = 0; s < 2; s++) begin
      ea_strap = s[0];
      foreach (int_list_dummy[i]) ;
      rd(12'h000, 1'b1); rd(12'h002, 1'b1); rd(12'h00E, 1'b1);
      rd(12'h00A, 1'b0); rd(12'h00A, 1'b1); rd(12'h00B, 1'b0);
      rd(12'h034, 1'b1); rd(12'h040, 1'b1); rd(12'h041, 1'b0);
      rd(12'h050, 1'b1); rd(12'h051, 1'b0); rd(12'h054, 1'b1);
      rd(12'h070, 1'b1); rd(12'h071, 1'b0);
      rd(12'h080, 1'b1); rd(12'h081, 1'b0);
    end

    // sizing with all ones: R4, R5, R6
    for (int i = 0; i < 6; i++) wr(12'(12'h010 + 4 * i), 32'hFFFFFFFF);
    for (int i = 0; i < 6; i++) rd(12'(12'h010 + 4 * i), 1'b1);
    wr(12'h010, 32'h0);
    rd(12'h010, 1'b1);
    wr(12'h014, 32'hA5A5A5FF);
    rd(12'h014, 1'b1);
    // command keeps only 16 bits: R3
    wr(12'h004, 32'hFFFFABCD);
    rd(12'h004, 1'b1);
    // writes to read-only words: R12, R2
    wr(12'h000, 32'h12345678); rd(12'h000, 1'b1);
    wr(12'h00E, 32'hFFFFFFFF); rd(12'h00E, 1'b1);
    wr(12'h070, 32'hFFFFFFFF); rd(12'h070, 1'b1);
    wr(12'h0C8, 32'hDEADBEEF); rd(12'h0C8, 1'b1);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0) ea_strap = ~ea_strap;
      if ($urandom_range(0, 2) == 0) wr(pick_offset(), $urandom());
      else rd(pick_offset(), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int int_list_dummy [1];
endmodule